// File: doc/BRIEF.md
# Banked High-Memory Overlay Switch Controller

This block decides whether the top twelve kilobytes of a 16-bit CPU address space, 0xD000 to 0xFFFF, are served by an overlay RAM or by the original ROM/bus. Sixteen soft-switch addresses set the mapping: an access to one of them updates the mapping, whether it is a read or a write. The mapping has four parts: which of two 4K banks backs the 0xD000 window, whether reads of the region come from RAM, whether writes go to RAM, and a one-shot arming latch that guards the write enable.

Every CPU access is presented for one clock with its strobe. The routing outputs and the read data are combinational from the current mapping and address. The mapping, and any RAM write, is committed on the clock edge that ends the access. Two status addresses report the bank and the read-enable state in bit 7, with the low seven bits taken from an external keyboard latch. The overlay storage is internal. Each window keeps 2^LOW_AW bytes per bank (0xD000 window) and 2^HIGH_AW bytes (0xE000 window). Offset bits above those widths are ignored, so the storage repeats across the window. Full size is LOW_AW=12 and HIGH_AW=13.

Top module: `highmem_overlay`

## Requirements
- R1: After reset the 0xD000 bank is bank 0, the arming latch is clear, RAM reads are off and RAM writes are on.
- R2: Only a valid access with address 0xC080 to 0xC08F changes the mapping, and both reads and writes in that range do. Accesses outside the range (for example 0xC07C or 0xC090) leave it unchanged.
- R3: Address bit 3 of a switch access picks the 0xD000 bank: 0 selects bank 0 and 1 selects bank 1. The two banks hold independent data.
- R4: A switch access turns RAM reads on when its address bits 1:0 are 00 or 11, and turns them off when they are 01 or 10.
- R5: A switch access with address bit 0 equal to 0 clears the arming latch and turns RAM writes off.
- R6: A switch write with address bit 0 equal to 1 clears the arming latch and leaves the RAM write state as it was.
- R7: A switch read with address bit 0 equal to 1 turns RAM writes on if the arming latch is already set, then sets the latch. Two such reads with no switch write or even switch access between them are needed to turn writes on. Accesses outside the switch range do not disturb the latch.
- R8: A valid read in 0xD000 to 0xFFFF asserts ramSel and returns RAM data when RAM reads are on; otherwise it asserts romSel and cpuRdata is 0. A valid write there asserts ramSel and stores the byte when RAM writes are on; otherwise it asserts romSel and the RAM is unchanged.
- R9: A read of 0xC011 returns bit 7 = 1 when bank 0 is selected. A read of 0xC012 returns bit 7 = 1 when RAM reads are on. Bits 6:0 of both are keyLatch.
- R10: The 0xE000 to 0xFFFF window is a single store, shared whatever bank is selected.
- R11: RAM index is bank with offset bits LOW_AW-1:0 in the 0xD000 window, and offset bits HIGH_AW-1:0 in the 0xE000 window. Higher offset bits are ignored.
- R12: Accesses outside 0xD000 to 0xFFFF assert neither ramSel nor romSel, and cpuRdata is 0 except for the status reads.
- R13: A mapping change made by one access applies to the very next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | An access is presented this cycle |
| cpuWe | input | 1 | 1 = write access, 0 = read access |
| cpuAddr | input | 16 | CPU byte address |
| cpuWdata | input | 8 | Write data |
| keyLatch | input | 7 | Keyboard latch bits for status bytes |
| cpuRdata | output | 8 | Read data from RAM or status, else 0 |
| ramSel | output | 1 | Current access is served by the overlay RAM |
| romSel | output | 1 | Current high-region access goes to the original ROM/bus |

## Verification
A wrong bank, read-enable or write-enable flag shows at the ports on the next access to the high region: the select outputs swap or the wrong byte returns, and the status bytes expose bank and read state one access after the switch. A wrong arming latch is invisible until a later odd switch read. It shows only when a following write to the region is routed to the ROM when it should reach the RAM, or the reverse. The bench therefore places a high-region write and a read-back after each arming sequence. It checks read-back values against bytes written earlier, which also catches stores that should have been blocked.

// File: rtl/hmem_pkg.sv
package hmem_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int KEY_W  = 7;

  localparam logic [ADDR_W-1:0] SWITCH_BASE = 16'hC080;
  localparam logic [ADDR_W-1:0] STAT_BANK   = 16'hC011;
  localparam logic [ADDR_W-1:0] STAT_READ   = 16'hC012;
  localparam logic [3:0]        LOW_PAGE    = 4'hD;

  typedef struct packed {
    logic ramRd;     // read served from RAM
    logic ramWr;     // write stored in RAM
    logic inLow;     // access falls in the banked 4K window
    logic bankSel;   // current bank for the 4K window
    logic stBank;    // bank status read
    logic stRead;    // read-enable status read
    logic readFlag;  // current read-enable state
  } hmemStrobe_t;
endpackage

// File: rtl/hmem_switch_ctl.sv
module hmem_switch_ctl
  import hmem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  output hmemStrobe_t       strobe,
  output logic              ramSel,
  output logic              romSel
);
  logic bankQ, readEnQ, writeEnQ, armedQ;
  logic bankD, readEnD, writeEnD, armedD;
  logic swHit, hiHit, lowHit, lowBitsMatch;

  assign swHit        = cpuValid && (cpuAddr[ADDR_W-1:4] == SWITCH_BASE[ADDR_W-1:4]);
  assign hiHit        = cpuValid && (cpuAddr[ADDR_W-1:12] >= LOW_PAGE);
  assign lowHit       = cpuAddr[ADDR_W-1:12] == LOW_PAGE;
  assign lowBitsMatch = cpuAddr[1] == cpuAddr[0];

  always_comb begin
    bankD    = bankQ;
    readEnD  = readEnQ;
    writeEnD = writeEnQ;
    armedD   = armedQ;
    if (swHit) begin
      bankD   = cpuAddr[3];
      readEnD = lowBitsMatch;
      if (!cpuAddr[0]) begin
        armedD   = 1'b0;
        writeEnD = 1'b0;
      end else if (cpuWe) begin
        armedD = 1'b0;
      end else begin
        if (armedQ) writeEnD = 1'b1;
        armedD = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ    <= 1'b0;
      readEnQ  <= 1'b0;
      writeEnQ <= 1'b1;
      armedQ   <= 1'b0;
    end else begin
      bankQ    <= bankD;
      readEnQ  <= readEnD;
      writeEnQ <= writeEnD;
      armedQ   <= armedD;
    end
  end

  always_comb begin
    strobe.ramRd    = hiHit && !cpuWe && readEnQ;
    strobe.ramWr    = hiHit && cpuWe && writeEnQ;
    strobe.inLow    = lowHit;
    strobe.bankSel  = bankQ;
    strobe.stBank   = cpuValid && !cpuWe && (cpuAddr == STAT_BANK);
    strobe.stRead   = cpuValid && !cpuWe && (cpuAddr == STAT_READ);
    strobe.readFlag = readEnQ;
    ramSel = strobe.ramRd || strobe.ramWr;
    romSel = hiHit && !(strobe.ramRd || strobe.ramWr);
  end

  // R2
  no_switch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !swHit |=> ($stable(bankQ) && $stable(readEnQ) && $stable(writeEnQ) && $stable(armedQ)));

  // R7
  wr_enable_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeEnQ) |-> $past(swHit && cpuAddr[0] && !cpuWe && armedQ));

  // R5
  wr_disable_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeEnQ) |-> $past(swHit && !cpuAddr[0]));

  // R7
  arm_after_odd_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swHit && cpuAddr[0] && !cpuWe) |=> armedQ);

  // R6
  odd_write_keeps_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swHit && cpuAddr[0] && cpuWe) |=> (!armedQ && (writeEnQ == $past(writeEnQ))));
endmodule

// File: rtl/hmem_ram_path.sv
module hmem_ram_path
  import hmem_pkg::*;
#(
  parameter int LOW_AW  = 8,
  parameter int HIGH_AW = 9
) (
  input  logic              clk,
  input  hmemStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [KEY_W-1:0]  keyLatch,
  output logic [DATA_W-1:0] cpuRdata
);
  localparam int LOW_DEPTH  = 2 * (1 << LOW_AW);
  localparam int HIGH_DEPTH = 1 << HIGH_AW;
  localparam int MAX_AW     = (LOW_AW > HIGH_AW) ? LOW_AW : HIGH_AW;

  logic [DATA_W-1:0] lowMem  [LOW_DEPTH];
  logic [DATA_W-1:0] highMem [HIGH_DEPTH];
  logic [LOW_AW:0]    lowIdx;
  logic [HIGH_AW-1:0] highIdx;
  logic [DATA_W-1:0]  ramWord;
  logic               unusedAddrBits;

  assign lowIdx         = {strobe.bankSel, cpuAddr[LOW_AW-1:0]};
  assign highIdx        = cpuAddr[HIGH_AW-1:0];
  assign unusedAddrBits = ^cpuAddr[ADDR_W-1:MAX_AW];

  always_ff @(posedge clk) begin
    if (strobe.ramWr) begin
      if (strobe.inLow) lowMem[lowIdx]   <= cpuWdata;
      else              highMem[highIdx] <= cpuWdata;
    end
  end

  assign ramWord = strobe.inLow ? lowMem[lowIdx] : highMem[highIdx];

  always_comb begin
    if (strobe.ramRd)       cpuRdata = ramWord;
    else if (strobe.stBank) cpuRdata = {!strobe.bankSel, keyLatch};
    else if (strobe.stRead) cpuRdata = {strobe.readFlag, keyLatch};
    else                    cpuRdata = '0;
  end

  // R8
  rd_wr_exclusive_chk: assert property (@(posedge clk)
    !(strobe.ramRd && strobe.ramWr));
endmodule

// File: rtl/highmem_overlay.sv
module highmem_overlay
  import hmem_pkg::*;
#(
  parameter int LOW_AW  = 8,
  parameter int HIGH_AW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [KEY_W-1:0]  keyLatch,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              ramSel,
  output logic              romSel
);
  hmemStrobe_t strobe;

  hmem_switch_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .strobe(strobe), .ramSel(ramSel), .romSel(romSel)
  );

  hmem_ram_path #(.LOW_AW(LOW_AW), .HIGH_AW(HIGH_AW)) u_path (
    .clk(clk), .strobe(strobe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .keyLatch(keyLatch), .cpuRdata(cpuRdata)
  );

  // R12
  outside_no_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1:12] < LOW_PAGE) |-> (!ramSel && !romSel));
endmodule

// File: tb/highmem_overlay_tb.sv
module highmem_overlay_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOW_AW  = 8;
  localparam int HIGH_AW = 9;
  localparam logic [6:0] KEY = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 1'b0;
  logic cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0;
  logic [6:0] keyLatch = KEY;
  logic [7:0] cpuRdata;
  logic ramSel, romSel;

  logic [7:0] obsRdata;
  logic obsRam, obsRom;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  highmem_overlay #(.LOW_AW(LOW_AW), .HIGH_AW(HIGH_AW)) u_dut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .keyLatch(keyLatch),
    .cpuRdata(cpuRdata), .ramSel(ramSel), .romSel(romSel)
  );

  task automatic acc(input logic [15:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    cpuValid = 1'b1; cpuAddr = a; cpuWe = w; cpuWdata = d;
    #1;
    obsRdata = cpuRdata; obsRam = ramSel; obsRom = romSel;
  endtask

  task automatic idle();
    @(negedge clk);
    cpuValid = 1'b0; cpuWe = 1'b0; cpuAddr = '0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic route(input string tag, input logic ram, input logic rom);
    chk({tag, " ramSel"}, {7'd0, obsRam}, {7'd0, ram});
    chk({tag, " romSel"}, {7'd0, obsRom}, {7'd0, rom});
  endtask

  task automatic testReset();
    acc(16'hC011, 0, 0); chk("R1 R9 bank status", obsRdata, {1'b1, KEY});
    acc(16'hC012, 0, 0); chk("R1 R9 read status", obsRdata, {1'b0, KEY});
    acc(16'hD005, 1, 8'h5A); route("R1 write enabled", 1, 0);
    acc(16'hD010, 1, 8'h22); route("R1 write enabled 2", 1, 0);
    acc(16'hD005, 0, 0); route("R1 R8 read to rom", 0, 1);
    chk("R8 rom read data", obsRdata, 8'h00);
  endtask

  task automatic testReadEnable();
    acc(16'hC080, 0, 0);
    acc(16'hC012, 0, 0); chk("R4 00 enables", obsRdata, {1'b1, KEY});
    acc(16'hD005, 0, 0); route("R13 R8 ram read", 1, 0);
    chk("R8 ram data", obsRdata, 8'h5A);
    acc(16'hC081, 0, 0);
    acc(16'hC012, 0, 0); chk("R4 01 disables", obsRdata, {1'b0, KEY});
    acc(16'hC082, 0, 0);
    acc(16'hC012, 0, 0); chk("R4 10 disables", obsRdata, {1'b0, KEY});
    acc(16'hC083, 0, 0);
    acc(16'hC012, 0, 0); chk("R4 11 enables", obsRdata, {1'b1, KEY});
    acc(16'hC081, 0, 0);
    acc(16'hC080, 1, 0);
    acc(16'hC012, 0, 0); chk("R2 switch write updates", obsRdata, {1'b1, KEY});
  endtask

  task automatic testArming();
    acc(16'hC083, 0, 0);
    acc(16'hD010, 1, 8'h55); route("R7 one read not enough", 0, 1);
    acc(16'hD010, 0, 0); chk("R8 blocked write kept", obsRdata, 8'h22);
    acc(16'hC083, 0, 0);
    acc(16'hD010, 1, 8'h33); route("R7 two reads enable", 1, 0);
    acc(16'hD010, 0, 0); chk("R7 stored", obsRdata, 8'h33);
    acc(16'hC080, 0, 0);
    acc(16'hD010, 1, 8'h44); route("R5 even disables", 0, 1);
    acc(16'hC083, 0, 0);
    acc(16'hC08B, 1, 0);
    acc(16'hC083, 0, 0);
    acc(16'hD010, 1, 8'h66); route("R6 odd write disarms", 0, 1);
    acc(16'hC083, 0, 0);
    acc(16'hC081, 1, 0);
    acc(16'hD010, 1, 8'h34); route("R6 odd write keeps enable", 1, 0);
    acc(16'hC083, 0, 0);
    acc(16'hD010, 0, 0); chk("R6 data stored", obsRdata, 8'h34);
  endtask

  task automatic testBank();
    acc(16'hC08B, 0, 0);
    acc(16'hC011, 0, 0); chk("R3 R9 bank1 status", obsRdata, {1'b0, KEY});
    acc(16'hD010, 1, 8'h77);
    acc(16'hE123, 1, 8'h44);
    acc(16'hC083, 0, 0);
    acc(16'hC011, 0, 0); chk("R3 R9 bank0 status", obsRdata, {1'b1, KEY});
    acc(16'hD010, 0, 0); chk("R3 bank0 data", obsRdata, 8'h34);
    acc(16'hE123, 0, 0); chk("R10 shared upper", obsRdata, 8'h44);
    acc(16'hC08B, 0, 0);
    acc(16'hD010, 0, 0); chk("R3 bank1 data", obsRdata, 8'h77);
  endtask

  task automatic testMirror();
    acc(16'hD100, 1, 8'h99);
    acc(16'hD000, 0, 0); chk("R11 low mirror", obsRdata, 8'h99);
    acc(16'hD010, 0, 0); chk("R11 low other offset", obsRdata, 8'h77);
    acc(16'hE200, 1, 8'hA5);
    acc(16'hE000, 0, 0); chk("R11 high mirror", obsRdata, 8'hA5);
    acc(16'hFF23, 0, 0); chk("R11 R10 top of window", obsRdata, 8'h44);
  endtask

  task automatic testOutside();
    acc(16'hC081, 0, 0);
    acc(16'hC090, 0, 0);
    acc(16'hC07C, 1, 0);
    acc(16'hC012, 0, 0); chk("R2 outside range ignored", obsRdata, {1'b0, KEY});
    acc(16'hCFFF, 0, 0); route("R12 below region", 0, 0);
    chk("R12 rdata zero", obsRdata, 8'h00);
    acc(16'h1234, 1, 8'hFF); route("R12 low write", 0, 0);
    acc(16'hD000, 0, 0); route("R13 read off to rom", 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadEnable();
    testArming();
    testBank();
    testMirror();
    testOutside();
    idle();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule